// File: doc/BRIEF.md
# Register-State CRC Signature Accumulator

This block compresses a processor's architectural register state into one 32-bit signature, so a trace of many instructions can be checked against a single number. Before each instruction executes, the processor pulses a start strobe with seven 16-bit register values: four general registers, the flag register, the stack pointer and the program counter. The block latches the seven values and folds them into a running CRC in a fixed order. Each fold runs eight single-bit reflected shift steps, one step per clock.

The signature starts at zero and has no final inversion. It keeps accumulating from one snapshot to the next until a synchronous clear. When each snapshot finishes, the signature is compared with an expected constant. The block then raises either a pass flag or a fail flag and keeps that flag until the next completion or clear. The running signature is visible at all times.

Top module: `regstate_crc_sig`

## Requirements
- R1: While reset is asserted and after it is released, `sig_o` is 0 and `busy_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: A start while idle and not clearing latches all seven inputs. `busy_o` rises in the next cycle and stays high for exactly 56 cycles (7 values × 8 steps).
- R3: Each value fold XORs the whole 16-bit value, zero-extended, into the low bits of the CRC. It then applies 8 steps. Each step shifts the CRC right by one and XORs 0xEDB88320 when the bit shifted out was 1. The CRC starts at 0 and has no output inversion.
- R4: Within a snapshot the values are folded in this sequence: r0, r1, r2, r3, flags, stack pointer, program counter.
- R5: The signature carries over from one snapshot into the next. While idle and not clearing, `sig_o` does not change.
- R6: A start that arrives while `busy_o` is high is ignored. It does not restart the run and its input values are not used.
- R7: Changes on the register inputs after the start has been accepted do not affect the signature.
- R8: `done_o` is a one-cycle pulse in the cycle after the final step, when `busy_o` has just fallen. At that point `sig_o` holds the finished signature.
- R9: When `done_o` rises, `pass_o` is 1 if the signature equals the expected constant (default 0xEE861173) and `fail_o` is 1 otherwise. The two are never high together, and each holds until the next completion or clear.
- R10: A synchronous `clear_i` sets the signature to 0, drops `pass_o`, `fail_o` and `busy_o` in the next cycle, aborts any run, and takes priority over a simultaneous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of signature and verdict |
| start_i | input | 1 | Snapshot strobe |
| r0_i | input | 16 | General register 0 |
| r1_i | input | 16 | General register 1 |
| r2_i | input | 16 | General register 2 |
| r3_i | input | 16 | General register 3 |
| flags_i | input | 16 | Flag register |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | Program counter |
| busy_o | output | 1 | Snapshot being folded |
| done_o | output | 1 | One-cycle completion pulse |
| sig_o | output | 32 | Running CRC signature |
| pass_o | output | 1 | Signature matched expected value |
| fail_o | output | 1 | Signature did not match |

## Verification
A wrong step counter or value index shows up at the ports in two ways. `busy_o` has the wrong length, and `sig_o` departs from the behavioural model within a single cycle, because every step moves the signature. A wrong fold order or a missed XOR has no visible effect until the step that consumes the affected value. From that step on, every following cycle's signature differs, and the verdict at `done_o` is wrong as well. The bench runs its model alongside the design and compares `busy_o`, `done_o`, `sig_o`, `pass_o` and `fail_o` on every clock. It therefore catches a divergence in the cycle where it first appears.

// File: rtl/regsig_pkg.sv
package regsig_pkg;
  // Number of register values folded per snapshot (fixed by the port list)
  localparam int NUM_VALS = 7;
  localparam int IDX_W    = $clog2(NUM_VALS);
endpackage

// File: rtl/regsig_hold.sv
// Holding register for one snapshot; slot k is read back by index.
module regsig_hold
  import regsig_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [NUM_VALS*DATA_W-1:0] vals_i,
  input  logic [IDX_W-1:0]           sel_i,
  output logic [DATA_W-1:0]          val_o
);
  logic [DATA_W-1:0] slot_q [NUM_VALS];

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_slot
    logic [DATA_W-1:0] slot_d;
    always_comb begin
      slot_d = slot_q[k];
      if (load_i) slot_d = vals_i[k*DATA_W +: DATA_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= '0;
      else        slot_q[k] <= slot_d;
    end
  end

  assign val_o = slot_q[sel_i];
endmodule

// File: rtl/regsig_step.sv
// One reflected CRC shift step, optionally preceded by the value XOR.
module regsig_step #(
  parameter int          DATA_W = 16,
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              mix_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int PAD_W = CRC_W - DATA_W;
  logic [CRC_W-1:0] mixed;

  always_comb begin
    mixed = crc_i;
    if (mix_i) mixed = crc_i ^ {{PAD_W{1'b0}}, val_i};
    crc_o = {1'b0, mixed[CRC_W-1:1]};
    if (mixed[0]) crc_o = crc_o ^ POLY[CRC_W-1:0];
  end
endmodule

// File: rtl/regsig_seq.sv
// Step/value sequencer: one shift step per clock while busy.
module regsig_seq
  import regsig_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mix_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int BIT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(STEPS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_VALS - 1);

  logic             busy_q, busy_d, done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    bit_d  = bit_q;
    done_d = 1'b0;
    if (clear_i) begin
      busy_d = 1'b0;
      idx_d  = '0;
      bit_d  = '0;
    end else if (busy_q) begin
      if (bit_q == BIT_LAST) begin
        bit_d = '0;
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
          idx_d  = '0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
      bit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign mix_o  = busy_q && (bit_q == '0);
  assign last_o = busy_q && (bit_q == BIT_LAST) && (idx_q == IDX_LAST);
endmodule

// File: rtl/regstate_crc_sig.sv
module regstate_crc_sig
  import regsig_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          CRC_W  = 32,
  parameter int          STEPS  = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320,
  parameter logic [31:0] EXPECT = 32'hEE861173
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] r0_i,
  input  logic [DATA_W-1:0] r1_i,
  input  logic [DATA_W-1:0] r2_i,
  input  logic [DATA_W-1:0] r3_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  sig_o,
  output logic              pass_o,
  output logic              fail_o
);
  // Slot order is the fold order: r0..r3, flags, stack pointer, program counter
  logic [NUM_VALS*DATA_W-1:0] snap_vec;
  assign snap_vec = {pc_i, sp_i, flags_i, r3_i, r2_i, r1_i, r0_i};

  logic             busy, mix, last, load;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] cur_val;
  logic [CRC_W-1:0] crc_q, crc_d, step_crc;
  logic             pass_q, pass_d, fail_q, fail_d;

  assign load = start_i && !busy && !clear_i;

  regsig_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
    .busy_o(busy), .done_o(done_o), .mix_o(mix), .last_o(last), .idx_o(idx)
  );

  regsig_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load), .vals_i(snap_vec),
    .sel_i(idx), .val_o(cur_val)
  );

  regsig_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i(crc_q), .val_i(cur_val), .mix_i(mix), .crc_o(step_crc)
  );

  always_comb begin
    crc_d  = crc_q;
    pass_d = pass_q;
    fail_d = fail_q;
    if (clear_i) begin
      crc_d  = '0;
      pass_d = 1'b0;
      fail_d = 1'b0;
    end else if (busy) begin
      crc_d = step_crc;
      if (last) begin
        pass_d = (step_crc == EXPECT[CRC_W-1:0]);
        fail_d = (step_crc != EXPECT[CRC_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign busy_o = busy;
  assign sig_o  = crc_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/regstate_crc_sig_chk.sv
module regstate_crc_sig_chk
  import regsig_pkg::*;
#(
  parameter int STEPS = 8,
  parameter int CRC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CRC_W-1:0] sig_o,
  input logic             pass_o,
  input logic             fail_o
);
  localparam int TOTAL = STEPS * NUM_VALS;
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + 16'd1;
    else             run_len <= '0;
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == 16'(TOTAL))); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !clear_i) |=> busy_o); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clear_i) |=> $stable(sig_o)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sig_o == '0 && !pass_o && !fail_o && !busy_o)); // R10
endmodule

bind regstate_crc_sig regstate_crc_sig_chk #(.STEPS(STEPS), .CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .sig_o(sig_o),
  .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/regstate_crc_sig_test.sv
module regstate_crc_sig_test;
  localparam int CLK_PERIOD = 10;

  // Bench-side CRC fold of one snapshot onto a starting signature
  function automatic logic [31:0] fold7(input logic [31:0] init,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
      input logic [15:0] d, input logic [15:0] e, input logic [15:0] f,
      input logic [15:0] g);
    logic [15:0] v [7];
    logic [31:0] x;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d; v[4] = e; v[5] = f; v[6] = g;
    x = init;
    for (int i = 0; i < 7; i++) begin
      x = x ^ {16'h0, v[i]};
      for (int s = 0; s < 8; s++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    end
    return x;
  endfunction

  localparam logic [31:0] EXP_A =
    fold7(32'h0, 16'h1234, 16'hABCD, 16'h0001, 16'hFFFF, 16'h0004, 16'h7FF0, 16'h0010);

  logic clk, rst_n, clear_i, start_i;
  logic [15:0] r0, r1, r2, r3, fl, sp, pc;
  logic busy_o, done_o, pass_o, fail_o;
  logic [31:0] sig_o;

  regstate_crc_sig #(.EXPECT(EXP_A)) uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
    .r0_i(r0), .r1_i(r1), .r2_i(r2), .r3_i(r3), .flags_i(fl), .sp_i(sp), .pc_i(pc),
    .busy_o(busy_o), .done_o(done_o), .sig_o(sig_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  int n_tests = 0, n_fail = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_vals [7];
  bit m_busy, m_done, m_pass, m_fail;
  int m_idx, m_bit;
  logic [31:0] m_crc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0; m_idx = 0; m_bit = 0; m_crc = 0;
    end else begin
      m_done = 0;
      if (clear_i) begin
        m_busy = 0; m_crc = 0; m_pass = 0; m_fail = 0;
      end else if (m_busy) begin
        if (m_bit == 0) m_crc = m_crc ^ 32'(m_vals[m_idx]);
        m_crc = m_crc[0] ? ((m_crc >> 1) ^ 32'hEDB88320) : (m_crc >> 1);
        m_bit++;
        if (m_bit == 8) begin
          m_bit = 0;
          m_idx++;
          if (m_idx == 7) begin
            m_busy = 0; m_done = 1;
            m_pass = (m_crc == EXP_A); m_fail = (m_crc != EXP_A);
          end
        end
      end else if (start_i) begin
        m_vals[0] = int'(r0); m_vals[1] = int'(r1); m_vals[2] = int'(r2);
        m_vals[3] = int'(r3); m_vals[4] = int'(fl); m_vals[5] = int'(sp);
        m_vals[6] = int'(pc);
        m_busy = 1; m_idx = 0; m_bit = 0;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(busy_o == m_busy, "R2 busy", 32'(busy_o), 32'(m_busy));
    check(done_o == m_done, "R8 done", 32'(done_o), 32'(m_done));
    check(sig_o == m_crc, "R3/R4 sig", sig_o, m_crc);
    check(pass_o == m_pass && fail_o == m_fail, "R9 verdict",
          {30'h0, pass_o, fail_o}, {30'h0, m_pass, m_fail});
  end

  task automatic set_regs(input logic [15:0] a, b, c, d, e, f, g);
    r0 = a; r1 = b; r2 = c; r3 = d; fl = e; sp = f; pc = g;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done_o; i++) @(negedge clk);
  endtask

  logic [31:0] sig_a;

  initial begin
    rst_n = 1'b0; clear_i = 1'b0; start_i = 1'b0;
    set_regs(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(sig_o == 0 && !busy_o && !done_o && !pass_o && !fail_o, "R1 reset",
          sig_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sig_o == 0 && !busy_o && !pass_o && !fail_o, "R1 after release", sig_o, 32'h0);

    // All-zero snapshot keeps signature zero, verdict fail
    pulse_start();
    check(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'h1);
    wait_done();
    check(sig_o == 32'h0, "R3 zero snapshot", sig_o, 32'h0);
    check(fail_o && !pass_o, "R9 fail on mismatch", {30'h0, pass_o, fail_o}, 32'h1);

    // Clear drops verdict
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(!fail_o && !pass_o && sig_o == 0, "R10 clear", sig_o, 32'h0);

    // Snapshot A with input changes and a second start during the run
    set_regs(16'h1234, 16'hABCD, 16'h0001, 16'hFFFF, 16'h0004, 16'h7FF0, 16'h0010);
    pulse_start();
    set_regs(16'hDEAD, 16'hBEEF, 16'h5555, 16'hAAAA, 16'h0002, 16'h0100, 16'h0200);
    repeat (10) @(negedge clk);
    pulse_start();  // R6: ignored while busy
    wait_done();
    check(sig_o == EXP_A, "R4/R7 order and holding", sig_o, EXP_A);
    check(pass_o && !fail_o, "R9 pass on match", {30'h0, pass_o, fail_o}, 32'h2);
    repeat (3) @(negedge clk);
    check(!busy_o && sig_o == EXP_A, "R6 restart ignored", sig_o, EXP_A);
    sig_a = sig_o;

    // Accumulation into the next snapshot
    pulse_start();
    wait_done();
    check(sig_o == fold7(sig_a, 16'hDEAD, 16'hBEEF, 16'h5555, 16'hAAAA, 16'h0002,
          16'h0100, 16'h0200), "R5 accumulate", sig_o,
          fold7(sig_a, 16'hDEAD, 16'hBEEF, 16'h5555, 16'hAAAA, 16'h0002, 16'h0100, 16'h0200));
    check(fail_o, "R9 fail after accumulate", 32'(fail_o), 32'h1);

    // Swapped stack pointer and program counter give a different signature
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    set_regs(16'h1234, 16'hABCD, 16'h0001, 16'hFFFF, 16'h0004, 16'h0010, 16'h7FF0);
    pulse_start();
    wait_done();
    check(sig_o == fold7(0, 16'h1234, 16'hABCD, 16'h0001, 16'hFFFF, 16'h0004, 16'h0010,
          16'h7FF0) && sig_o != EXP_A, "R4 swapped order", sig_o, EXP_A);

    // Clear mid-run aborts; clear with start wins
    pulse_start();
    repeat (5) @(negedge clk);
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(!busy_o && sig_o == 0, "R10 abort", sig_o, 32'h0);
    clear_i = 1'b1; start_i = 1'b1; @(negedge clk); clear_i = 1'b0; start_i = 1'b0;
    check(!busy_o, "R10 clear over start", 32'(busy_o), 32'h0);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", cycles, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule